// File: doc/BRIEF.md
# Clock Synthesizer Configuration Word Loader

This block keeps the configuration word that steers a frequency synthesizer. The word has three fields: a 7-bit feedback divider value, a 2-bit output divider select and a 3-bit test output select. Two independent load paths can write it.

The serial path has a 12-bit shift register, fed from a serial data pin and clocked by a slow serial clock pin. A serial load strobe makes the shifted word visible. The parallel path takes the divider and divider-select fields straight from input pins under a parallel load strobe. The two strobes have opposite polarity. Each path acts like a level-sensitive latch: the outputs follow the path while its strobe is active and freeze when the strobe goes inactive. The test field can be written only through the serial path.

All external pins are brought into a fast system clock domain through two-flop synchronizers. Latch transparency is then modelled once per system clock cycle.

Top module: `cfg_load_if`

## Requirements
- R1: After reset the shift register is cleared and all three output fields read zero. The parallel strobe's synchronizer resets to its inactive level (HIGH).
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of the 12-bit shift register, and the older bits move up by one. After 12 shifts, bits 11..9 hold the test field, bits 8..7 hold the output divider select and bits 6..0 hold the divider value. The frame is therefore sent MSB first in the order test, select, divider.
- R3: While the synchronized serial strobe is HIGH, the three output fields follow the shift register, including any bits shifted in while the strobe stays HIGH.
- R4: After the serial strobe falls, further serial clocks and data leave the outputs unchanged.
- R5: While the parallel strobe is LOW and the serial strobe is LOW, the divider and select outputs follow the parallel pins, and the test field keeps its value.
- R6: After the parallel strobe rises, changes on the parallel pins leave the outputs unchanged.
- R7: When both strobes are active at once, the outputs follow the shift register and not the parallel pins.
- R8: With both strobes inactive (serial LOW, parallel HIGH), the outputs hold whatever happens on the data pins and the serial clock.
- R9: A change on the parallel pins under an active parallel strobe reaches the outputs on the third system clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled |
| ser_dat_i | input | 1 | Serial data bit |
| ser_ld_i | input | 1 | Serial load strobe, active HIGH |
| par_ld_i | input | 1 | Parallel load strobe, active LOW |
| par_div_i | input | 7 | Parallel divider value |
| par_sel_i | input | 2 | Parallel output divider select |
| div_o | output | 7 | Feedback divider value |
| sel_o | output | 2 | Output divider select |
| tst_o | output | 3 | Test output select |

## Verification
Every pin crosses two synchronizer flops, so each result lands a fixed number of system edges after the pin changes:
- A parallel pin change shows on the outputs at the third edge.
- A serial strobe rise exposes the shift register at the third edge.
- A serial clock rise updates the shift register at the third edge and the outputs at the fourth.

The bench drives all pins on falling clock edges and samples on falling edges. Directed checks wait at least five cycles after a stimulus before comparing. The latency check (R9) samples the output exactly after the second edge, where the old value is expected, and again after the third edge, where the new value is expected.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  parameter int unsigned DIV_W   = 7;
  parameter int unsigned SEL_W   = 2;
  parameter int unsigned TST_W   = 3;
  parameter int unsigned FRAME_W = DIV_W + SEL_W + TST_W;

  typedef struct packed {
    logic [TST_W-1:0] tst;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic         sedge_o,
  output logic [W-1:0] shift_o
);
  logic         sclk_q;
  logic [W-1:0] shift_q;
  logic [W-1:0] shift_d;

  assign sedge_o = sclk_s & ~sclk_q;

  always_comb begin
    shift_d = shift_q;
    if (sedge_o) shift_d = {shift_q[W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
    end else begin
      sclk_q  <= sclk_s;
      shift_q <= shift_d;
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_load_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sld_s,
  input  logic                pld_s,
  input  logic [FRAME_W-1:0]  shift_i,
  input  logic [DIV_W-1:0]    pdiv_s,
  input  logic [SEL_W-1:0]    psel_s,
  output cfg_word_t           cfg_o
);
  cfg_word_t cfg_q;
  cfg_word_t cfg_d;
  logic      cfg_en;

  always_comb begin
    cfg_en = sld_s | ~pld_s;
    cfg_d  = cfg_q;
    if (sld_s) begin
      cfg_d = cfg_word_t'(shift_i);
    end else if (!pld_s) begin
      cfg_d.div = pdiv_s;
      cfg_d.sel = psel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cfg_load_if.sv
module cfg_load_if
  import cfg_load_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_ld_i,
  input  logic             par_ld_i,
  input  logic [DIV_W-1:0] par_div_i,
  input  logic [SEL_W-1:0] par_sel_i,
  output logic [DIV_W-1:0] div_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [TST_W-1:0] tst_o
);
  localparam int unsigned SYNC_W = 4 + DIV_W + SEL_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b0001, {(DIV_W + SEL_W){1'b0}}};

  logic [SYNC_W-1:0]  sync_d;
  logic [SYNC_W-1:0]  sync_q;
  logic               sclk_s;
  logic               sdat_s;
  logic               sld_s;
  logic               pld_s;
  logic [DIV_W-1:0]   pdiv_s;
  logic [SEL_W-1:0]   psel_s;
  logic               sedge;
  logic [FRAME_W-1:0] shift_q;
  cfg_word_t          cfg;

  assign sync_d = {ser_clk_i, ser_dat_i, ser_ld_i, par_ld_i, par_div_i, par_sel_i};

  cfg_sync2 #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {sclk_s, sdat_s, sld_s, pld_s, pdiv_s, psel_s} = sync_q;

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .sdat_s  (sdat_s),
    .sedge_o (sedge),
    .shift_o (shift_q)
  );

  cfg_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .sld_s   (sld_s),
    .pld_s   (pld_s),
    .shift_i (shift_q),
    .pdiv_s  (pdiv_s),
    .psel_s  (psel_s),
    .cfg_o   (cfg)
  );

  assign div_o = cfg.div;
  assign sel_o = cfg.sel;
  assign tst_o = cfg.tst;
endmodule

// File: rtl/cfg_load_if_chk.sv
module cfg_load_if_chk
  import cfg_load_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sld_s,
  input logic               pld_s,
  input logic               sedge,
  input logic               sdat_s,
  input logic [FRAME_W-1:0] shift_q,
  input logic [DIV_W-1:0]   pdiv_s,
  input logic [SEL_W-1:0]   psel_s,
  input logic [DIV_W-1:0]   div_o,
  input logic [SEL_W-1:0]   sel_o,
  input logic [TST_W-1:0]   tst_o
);
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sedge |=> shift_q == {$past(shift_q[FRAME_W-2:0]), $past(sdat_s)});

  p_ser_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sld_s |=> {tst_o, sel_o, div_o} == $past(shift_q));

  p_par_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sld_s && !pld_s) |=> (div_o == $past(pdiv_s)) && (sel_o == $past(psel_s)) && $stable(tst_o));

  p_ser_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sld_s && !pld_s) |=> tst_o == $past(shift_q[FRAME_W-1:FRAME_W-TST_W]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sld_s && pld_s) |=> $stable({tst_o, sel_o, div_o}));
endmodule

bind cfg_load_if cfg_load_if_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sld_s   (sld_s),
  .pld_s   (pld_s),
  .sedge   (sedge),
  .sdat_s  (sdat_s),
  .shift_q (shift_q),
  .pdiv_s  (pdiv_s),
  .psel_s  (psel_s),
  .div_o   (div_o),
  .sel_o   (sel_o),
  .tst_o   (tst_o)
);

// File: tb/cfg_load_if_tb.sv
module cfg_load_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       ser_clk_i, ser_dat_i, ser_ld_i, par_ld_i;
  logic [6:0] par_div_i;
  logic [1:0] par_sel_i;
  logic [6:0] div_o;
  logic [1:0] sel_o;
  logic [2:0] tst_o;

  int n_chk;
  int n_fail;
  logic [11:0] exp_cfg;
  logic [11:0] exp_shift;

  cfg_load_if u_dut (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .ser_ld_i(ser_ld_i),
    .par_ld_i(par_ld_i), .par_div_i(par_div_i), .par_sel_i(par_sel_i),
    .div_o(div_o), .sel_o(sel_o), .tst_o(tst_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] mk_frame(logic [2:0] t, logic [1:0] s, logic [6:0] d);
    return {t, s, d};
  endfunction

  function automatic logic [11:0] par_apply(logic [11:0] cur, logic [6:0] d, logic [1:0] s);
    return {cur[11:9], s, d};
  endfunction

  task automatic chk(string req, logic [11:0] exp);
    n_chk++;
    if ({tst_o, sel_o, div_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, {tst_o, sel_o, div_o}, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(logic b);
    ser_dat_i = b;
    ser_clk_i = 1'b0;
    wait_n(3);
    ser_clk_i = 1'b1;
    wait_n(3);
    ser_clk_i = 1'b0;
    exp_shift = {exp_shift[10:0], b};
  endtask

  task automatic ser_frame(logic [11:0] f);
    for (int i = 11; i >= 0; i--) ser_bit(f[i]);
    wait_n(3);
  endtask

  task automatic ser_strobe();
    ser_ld_i = 1'b1;
    wait_n(5);
    ser_ld_i = 1'b0;
    wait_n(5);
    exp_cfg = exp_shift;
  endtask

  task automatic par_load(logic [6:0] d, logic [1:0] s);
    par_div_i = d;
    par_sel_i = s;
    par_ld_i  = 1'b0;
    wait_n(5);
    par_ld_i  = 1'b1;
    wait_n(5);
    exp_cfg = par_apply(exp_cfg, d, s);
  endtask

  initial begin
    wait_n(WATCHDOG);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] f;
    logic [6:0]  d;
    logic [1:0]  s;
    int unsigned seed;
    n_chk = 0; n_fail = 0;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    ser_clk_i = 1'b0; ser_dat_i = 1'b0; ser_ld_i = 1'b0; par_ld_i = 1'b1;
    par_div_i = 7'h7f; par_sel_i = 2'h3;
    exp_cfg = '0; exp_shift = '0;
    wait_n(3);
    chk("R1 reset", 12'h000);
    rst_n = 1'b1;
    wait_n(5);
    chk("R1 after release", 12'h000);

    // R2/R3: directed frame
    f = mk_frame(3'd5, 2'd2, 7'h55);
    ser_frame(f);
    chk("R4 shift without strobe", 12'h000);
    ser_strobe();
    chk("R2 frame order", f);

    // R3: transparency while strobe held high
    ser_ld_i = 1'b1;
    wait_n(5);
    ser_bit(1'b1);
    wait_n(4);
    chk("R3 follow while high", exp_shift);
    ser_ld_i = 1'b0;
    wait_n(5);
    exp_cfg = exp_shift;

    // R4: shifting after close has no effect
    ser_frame(12'hA3C);
    chk("R4 hold after fall", exp_cfg);

    // R5: parallel follow, test field kept
    par_div_i = 7'h12; par_sel_i = 2'd1; par_ld_i = 1'b0;
    wait_n(5);
    chk("R5 parallel follow", par_apply(exp_cfg, 7'h12, 2'd1));
    par_div_i = 7'h6e; par_sel_i = 2'd3;
    wait_n(5);
    chk("R5 parallel follow change", par_apply(exp_cfg, 7'h6e, 2'd3));

    // R9: latency, driven at negedge
    par_div_i = 7'h01; par_sel_i = 2'd0;
    wait_n(2);
    chk("R9 not before third edge", par_apply(exp_cfg, 7'h6e, 2'd3));
    wait_n(1);
    chk("R9 at third edge", par_apply(exp_cfg, 7'h01, 2'd0));
    par_ld_i = 1'b1;
    wait_n(5);
    exp_cfg = par_apply(exp_cfg, 7'h01, 2'd0);

    // R6: hold after parallel strobe rises
    par_div_i = 7'h40; par_sel_i = 2'd2;
    wait_n(6);
    chk("R6 hold after rise", exp_cfg);

    // R7: both active, serial wins
    par_div_i = 7'h0f; par_sel_i = 2'd1; par_ld_i = 1'b0;
    ser_ld_i = 1'b1;
    wait_n(6);
    chk("R7 serial priority", exp_shift);
    ser_ld_i = 1'b0;
    par_ld_i = 1'b1;
    wait_n(6);
    exp_cfg = exp_shift;
    chk("R7 after release", exp_cfg);

    // R8: idle, wiggle everything
    par_div_i = 7'h33; par_sel_i = 2'd2;
    ser_bit(1'b1); ser_bit(1'b0);
    wait_n(4);
    chk("R8 idle hold", exp_cfg);

    // random mix
    for (int i = 0; i < 20; i++) begin
      f = 12'($urandom());
      ser_frame(f);
      ser_strobe();
      chk("R2 random frame", f);
      d = 7'($urandom());
      s = 2'($urandom());
      par_load(d, s);
      chk("R5 random parallel", exp_cfg);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule